// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block passes data between two buses, A and B, split into byte lanes that run independently. Each lane holds two storage registers. The A-side register records bus A and the B-side register records bus B. For each direction, a path-select input decides what reaches the driven bus: the live value of the opposite bus, or the value held in the register. Tying the control vectors of all lanes together gives one full-width transceiver.

Each bus port is modelled as three pieces. The first is the value driven by any external device (`a_in`, `b_in`) together with a per-lane flag that says whether an external device is driving. The second is the block's own output and its output enable. The third is the resolved bus value that all parties see. A lane raises a conflict flag when the block and an external device drive the same bus together. Capture strobes are sampled on the system clock, and a register loads on a low-to-high change of its strobe.

When both directions are enabled and both selects are live, each bus would feed the other with no source of its own. The block models this case with a per-lane hold register. The hold register follows whichever bus an external device drives and supplies the shared value after the external drivers release.

Top module: `regd_bus_xcvr`

## Requirements
- R1: Asynchronous active-low reset clears both registers and the hold register of every lane to zero; after reset, stored-mode and drive-both live-mode outputs read zero.
- R2: The A-side register of a lane loads that lane's resolved A bus at the clock edge where `stb_ab` is seen high after being low. The new value appears on the following cycle. Loading happens regardless of selects and enables. Keeping `stb_ab` high does not load again.
- R3: The B-side register of a lane loads that lane's resolved B bus at the clock edge where `stb_ba` is seen high after being low, under the same rules as R2.
- R4: `drive_b` is active high and sets `b_oe`. `drive_a_n` is active low and sets `a_oe`. With `drive_b`=0 and `drive_a_n`=1 (isolation), each resolved bus equals its external input.
- R5: With `b_oe` on, `use_reg_ab`=0 puts the lane's resolved A bus on `b_out` in the same cycle, and `use_reg_ab`=1 puts the A-side register there.
- R6: With `a_oe` on, `use_reg_ba`=0 puts the lane's resolved B bus on `a_out` in the same cycle, and `use_reg_ba`=1 puts the B-side register there.
- R7: Lane n owns data bits [8n+7:8n] and bit n of every control, enable and flag vector; no lane's controls affect another lane.
- R8: With both directions enabled and both selects at 0, the two resolved buses are equal. They follow an external driver when one is present (A side first). With no external driver, they hold the last externally driven value.
- R9: The lane conflict flag is set in the same cycle in which a bus has both its block output enable and its external drive flag on, and is clear otherwise.
- R10: With both directions enabled and both selects at 1, the A-side register drives bus B and the B-side register drives bus A at the same time.
- R11: While bus A is driven externally and passed live to bus B, strobing both capture inputs together stores the A value in both registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_in | input | LANES*LANE_W | Value an external device places on bus A |
| a_ext_en | input | LANES | Per-lane flag: an external device drives bus A |
| b_in | input | LANES*LANE_W | Value an external device places on bus B |
| b_ext_en | input | LANES | Per-lane flag: an external device drives bus B |
| stb_ab | input | LANES | Capture strobe for the A-side register |
| stb_ba | input | LANES | Capture strobe for the B-side register |
| use_reg_ab | input | LANES | B-bus source: 0 live A bus, 1 A-side register |
| use_reg_ba | input | LANES | A-bus source: 0 live B bus, 1 B-side register |
| drive_b | input | LANES | Active-high enable for driving bus B |
| drive_a_n | input | LANES | Active-low enable for driving bus A |
| a_out | output | LANES*LANE_W | Block value for bus A, meaningful while `a_oe` is on |
| a_oe | output | LANES | Block drives bus A |
| a_bus | output | LANES*LANE_W | Resolved bus A value |
| b_out | output | LANES*LANE_W | Block value for bus B, meaningful while `b_oe` is on |
| b_oe | output | LANES | Block drives bus B |
| b_bus | output | LANES*LANE_W | Resolved bus B value |
| conflict | output | LANES | Per-lane driver conflict flag |

## Verification
The enables, both bus paths and the conflict flag respond in the cycle in which their inputs change. The bench therefore applies each step one time unit after a rising edge and reads these results at the falling edge of that same cycle. A register load takes effect at the rising edge that closes the step in which its strobe is first seen high, so each table step that strobes is followed by a step that reads the register through a stored path. The hold register follows external data at the same edge, so each drive-both live check comes at least one step after the external value it should keep.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

   typedef enum logic [1:0] {
      DIR_NONE = 2'b00,
      DIR_TO_B = 2'b01,
      DIR_TO_A = 2'b10,
      DIR_BOTH = 2'b11
   } dir_e;

   typedef struct packed {
      logic use_reg_ab;
      logic use_reg_ba;
      logic drive_b;
      logic drive_a_n;
   } lane_ctl_t;

   function automatic dir_e dir_of(input lane_ctl_t c);
      return dir_e'({~c.drive_a_n, c.drive_b});
   endfunction

endpackage

// File: rtl/xcvr_strobe_edge.sv
module xcvr_strobe_edge #(
   parameter int unsigned N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] strobe,
   output logic [N-1:0] rise
);

   generate
      for (genvar i = 0; i < N; i++) begin : g_bit
         logic prev_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev_q <= 1'b0;
            else        prev_q <= strobe[i];
         end
         assign rise[i] = strobe[i] & ~prev_q;
      end
   endgenerate

endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane
   import xcvr_pkg::*;
#(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] a_in,
   input  logic         a_ext,
   input  logic [W-1:0] b_in,
   input  logic         b_ext,
   input  logic         load_a,
   input  logic         load_b,
   input  lane_ctl_t    ctl,
   output logic [W-1:0] a_out,
   output logic         a_oe,
   output logic [W-1:0] a_bus,
   output logic [W-1:0] b_out,
   output logic         b_oe,
   output logic [W-1:0] b_bus,
   output logic         conflict
);

   logic [W-1:0] reg_a_q, reg_b_q, hold_q, loop_val;
   dir_e         dir;

   assign dir  = dir_of(ctl);
   assign a_oe = (dir == DIR_TO_A) || (dir == DIR_BOTH);
   assign b_oe = (dir == DIR_TO_B) || (dir == DIR_BOTH);

   // Value shared by both buses when each feeds the other live
   always_comb begin
      if (a_ext)      loop_val = a_in;
      else if (b_ext) loop_val = b_in;
      else            loop_val = hold_q;
   end

   // Each output is resolved from the inputs directly, so no
   // combinational path runs from a bus back into itself.
   always_comb begin
      if (ctl.use_reg_ba)      a_out = reg_b_q;
      else if (!b_oe)          a_out = b_in;
      else if (ctl.use_reg_ab) a_out = reg_a_q;
      else                     a_out = loop_val;
   end

   always_comb begin
      if (ctl.use_reg_ab)      b_out = reg_a_q;
      else if (!a_oe)          b_out = a_in;
      else if (ctl.use_reg_ba) b_out = reg_b_q;
      else                     b_out = loop_val;
   end

   assign a_bus    = a_oe ? a_out : a_in;
   assign b_bus    = b_oe ? b_out : b_in;
   assign conflict = (a_oe & a_ext) | (b_oe & b_ext);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reg_a_q <= '0;
         reg_b_q <= '0;
      end else begin
         if (load_a) reg_a_q <= a_bus;
         if (load_b) reg_b_q <= b_bus;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     hold_q <= '0;
      else if (a_ext) hold_q <= a_in;
      else if (b_ext) hold_q <= b_in;
   end

endmodule

// File: rtl/regd_bus_xcvr.sv
module regd_bus_xcvr
   import xcvr_pkg::*;
#(
   parameter int unsigned LANES  = 2,
   parameter int unsigned LANE_W = 8,
   localparam int unsigned DW    = LANES * LANE_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DW-1:0]    a_in,
   input  logic [LANES-1:0] a_ext_en,
   input  logic [DW-1:0]    b_in,
   input  logic [LANES-1:0] b_ext_en,
   input  logic [LANES-1:0] stb_ab,
   input  logic [LANES-1:0] stb_ba,
   input  logic [LANES-1:0] use_reg_ab,
   input  logic [LANES-1:0] use_reg_ba,
   input  logic [LANES-1:0] drive_b,
   input  logic [LANES-1:0] drive_a_n,
   output logic [DW-1:0]    a_out,
   output logic [LANES-1:0] a_oe,
   output logic [DW-1:0]    a_bus,
   output logic [DW-1:0]    b_out,
   output logic [LANES-1:0] b_oe,
   output logic [DW-1:0]    b_bus,
   output logic [LANES-1:0] conflict
);

   generate
      if (LANES < 1) begin : g_bad_lanes
         $error("regd_bus_xcvr: LANES must be at least 1");
      end
      if (LANE_W < 1) begin : g_bad_width
         $error("regd_bus_xcvr: LANE_W must be at least 1");
      end
   endgenerate

   logic [LANES-1:0] rise_ab, rise_ba;

   xcvr_strobe_edge #(.N(LANES)) u_edge_ab (
      .clk(clk), .rst_n(rst_n), .strobe(stb_ab), .rise(rise_ab)
   );

   xcvr_strobe_edge #(.N(LANES)) u_edge_ba (
      .clk(clk), .rst_n(rst_n), .strobe(stb_ba), .rise(rise_ba)
   );

   generate
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         lane_ctl_t ctl;
         assign ctl = '{use_reg_ab: use_reg_ab[l], use_reg_ba: use_reg_ba[l],
                        drive_b: drive_b[l], drive_a_n: drive_a_n[l]};

         xcvr_lane #(.W(LANE_W)) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .a_in     (a_in[l*LANE_W +: LANE_W]),
            .a_ext    (a_ext_en[l]),
            .b_in     (b_in[l*LANE_W +: LANE_W]),
            .b_ext    (b_ext_en[l]),
            .load_a   (rise_ab[l]),
            .load_b   (rise_ba[l]),
            .ctl      (ctl),
            .a_out    (a_out[l*LANE_W +: LANE_W]),
            .a_oe     (a_oe[l]),
            .a_bus    (a_bus[l*LANE_W +: LANE_W]),
            .b_out    (b_out[l*LANE_W +: LANE_W]),
            .b_oe     (b_oe[l]),
            .b_bus    (b_bus[l*LANE_W +: LANE_W]),
            .conflict (conflict[l])
         );
      end
   endgenerate

endmodule

// File: rtl/regd_bus_xcvr_chk.sv
module regd_bus_xcvr_chk #(
   parameter int unsigned LANES  = 2,
   parameter int unsigned LANE_W = 8,
   localparam int unsigned DW    = LANES * LANE_W
) (
   input logic             clk,
   input logic             rst_n,
   input logic [DW-1:0]    a_in,
   input logic [LANES-1:0] a_ext_en,
   input logic [DW-1:0]    b_in,
   input logic [LANES-1:0] b_ext_en,
   input logic [LANES-1:0] stb_ab,
   input logic [LANES-1:0] stb_ba,
   input logic [LANES-1:0] use_reg_ab,
   input logic [LANES-1:0] use_reg_ba,
   input logic [LANES-1:0] drive_b,
   input logic [LANES-1:0] drive_a_n,
   input logic [DW-1:0]    a_out,
   input logic [LANES-1:0] a_oe,
   input logic [DW-1:0]    a_bus,
   input logic [DW-1:0]    b_out,
   input logic [LANES-1:0] b_oe,
   input logic [DW-1:0]    b_bus,
   input logic [LANES-1:0] conflict
);

   logic [LANES-1:0] stb_ab_q, stb_ba_q, edge_ab_q, edge_ba_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stb_ab_q  <= '0;
         stb_ba_q  <= '0;
         edge_ab_q <= '0;
         edge_ba_q <= '0;
      end else begin
         stb_ab_q  <= stb_ab;
         stb_ba_q  <= stb_ba;
         edge_ab_q <= stb_ab & ~stb_ab_q;
         edge_ba_q <= stb_ba & ~stb_ba_q;
      end
   end

   generate
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         logic loop_mode;
         assign loop_mode = drive_b[l] & ~drive_a_n[l] & ~use_reg_ab[l] & ~use_reg_ba[l];

         AST_REG_A_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
            (use_reg_ab[l] && $past(use_reg_ab[l]) && !edge_ab_q[l])
            |-> $stable(b_out[l*LANE_W +: LANE_W])); // R2

         AST_REG_B_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
            (use_reg_ba[l] && $past(use_reg_ba[l]) && !edge_ba_q[l])
            |-> $stable(a_out[l*LANE_W +: LANE_W])); // R3

         AST_ISOLATION: assert property (@(posedge clk) disable iff (!rst_n)
            (!drive_b[l] && drive_a_n[l])
            |-> (a_bus[l*LANE_W +: LANE_W] == a_in[l*LANE_W +: LANE_W] &&
                 b_bus[l*LANE_W +: LANE_W] == b_in[l*LANE_W +: LANE_W])); // R4

         AST_LIVE_TO_B: assert property (@(posedge clk) disable iff (!rst_n)
            (b_oe[l] && !a_oe[l] && !use_reg_ab[l])
            |-> b_out[l*LANE_W +: LANE_W] == a_in[l*LANE_W +: LANE_W]); // R5

         AST_LIVE_TO_A: assert property (@(posedge clk) disable iff (!rst_n)
            (a_oe[l] && !b_oe[l] && !use_reg_ba[l])
            |-> a_out[l*LANE_W +: LANE_W] == b_in[l*LANE_W +: LANE_W]); // R6

         AST_LOOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            (loop_mode && $past(loop_mode) && !a_ext_en[l] && !b_ext_en[l] &&
             !$past(a_ext_en[l]) && !$past(b_ext_en[l]))
            |-> ($stable(a_bus[l*LANE_W +: LANE_W]) &&
                 a_bus[l*LANE_W +: LANE_W] == b_bus[l*LANE_W +: LANE_W])); // R8

         AST_NO_FALSE_CONFLICT: assert property (@(posedge clk) disable iff (!rst_n)
            (!a_ext_en[l] && !b_ext_en[l]) |-> !conflict[l]); // R9
      end
   endgenerate

endmodule

bind regd_bus_xcvr regd_bus_xcvr_chk #(.LANES(LANES), .LANE_W(LANE_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .a_in(a_in), .a_ext_en(a_ext_en), .b_in(b_in),
   .b_ext_en(b_ext_en), .stb_ab(stb_ab), .stb_ba(stb_ba),
   .use_reg_ab(use_reg_ab), .use_reg_ba(use_reg_ba), .drive_b(drive_b),
   .drive_a_n(drive_a_n), .a_out(a_out), .a_oe(a_oe), .a_bus(a_bus),
   .b_out(b_out), .b_oe(b_oe), .b_bus(b_bus), .conflict(conflict)
);

// File: tb/regd_bus_xcvr_test.sv
module regd_bus_xcvr_test;

   localparam int CLK_P  = 10;
   localparam int LANES  = 2;
   localparam int LANE_W = 8;
   localparam int DW     = LANES * LANE_W;

   logic             clk = 1'b0;
   logic             rst_n;
   logic [DW-1:0]    a_in, b_in;
   logic [LANES-1:0] a_ext_en, b_ext_en, stb_ab, stb_ba;
   logic [LANES-1:0] use_reg_ab, use_reg_ba, drive_b, drive_a_n;
   logic [DW-1:0]    a_out, a_bus, b_out, b_bus;
   logic [LANES-1:0] a_oe, b_oe, conflict;

   int  n_chk  = 0;
   int  n_fail = 0;
   bit  done   = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   regd_bus_xcvr #(.LANES(LANES), .LANE_W(LANE_W)) uut (
      .clk(clk), .rst_n(rst_n), .a_in(a_in), .a_ext_en(a_ext_en),
      .b_in(b_in), .b_ext_en(b_ext_en), .stb_ab(stb_ab), .stb_ba(stb_ba),
      .use_reg_ab(use_reg_ab), .use_reg_ba(use_reg_ba), .drive_b(drive_b),
      .drive_a_n(drive_a_n), .a_out(a_out), .a_oe(a_oe), .a_bus(a_bus),
      .b_out(b_out), .b_oe(b_oe), .b_bus(b_bus), .conflict(conflict)
   );

   typedef struct packed {
      logic [23:0] tag;
      logic [15:0] ain, bin;
      logic aext, bext, sab_stb, sba_stb, rab, rba, drb, dran;
      logic [15:0] exp_a, exp_b;
      logic        exp_cf;
   } vec_t;

   localparam int NV = 18;
   // tag, a_in, b_in, a_ext, b_ext, stb_ab, stb_ba, use_reg_ab, use_reg_ba,
   // drive_b, drive_a_n, expected a_bus, expected b_bus, expected conflict
   localparam vec_t VT [NV] = '{
      '{"R4",  16'h1111, 16'h2222, 1'b1,1'b1, 1'b0,1'b0, 1'b0,1'b0, 1'b0,1'b1, 16'h1111, 16'h2222, 1'b0},
      '{"R3",  16'h1111, 16'h2222, 1'b1,1'b1, 1'b1,1'b1, 1'b0,1'b0, 1'b0,1'b1, 16'h1111, 16'h2222, 1'b0},
      '{"R5",  16'h3333, 16'h2222, 1'b1,1'b0, 1'b0,1'b0, 1'b1,1'b0, 1'b1,1'b1, 16'h3333, 16'h1111, 1'b0},
      '{"R5",  16'h3333, 16'h2222, 1'b1,1'b0, 1'b0,1'b0, 1'b0,1'b0, 1'b1,1'b1, 16'h3333, 16'h3333, 1'b0},
      '{"R6",  16'h3333, 16'h4444, 1'b0,1'b1, 1'b0,1'b0, 1'b0,1'b1, 1'b0,1'b0, 16'h2222, 16'h4444, 1'b0},
      '{"R6",  16'h3333, 16'h4444, 1'b0,1'b1, 1'b0,1'b0, 1'b0,1'b0, 1'b0,1'b0, 16'h4444, 16'h4444, 1'b0},
      '{"R10", 16'h5555, 16'h6666, 1'b0,1'b0, 1'b0,1'b0, 1'b1,1'b1, 1'b1,1'b0, 16'h2222, 16'h1111, 1'b0},
      '{"R9",  16'h5555, 16'h6666, 1'b1,1'b0, 1'b0,1'b0, 1'b1,1'b1, 1'b1,1'b0, 16'h2222, 16'h1111, 1'b1},
      '{"R11", 16'h7777, 16'h6666, 1'b1,1'b0, 1'b1,1'b1, 1'b0,1'b0, 1'b1,1'b1, 16'h7777, 16'h7777, 1'b0},
      '{"R11", 16'h5555, 16'h6666, 1'b0,1'b0, 1'b0,1'b0, 1'b1,1'b1, 1'b1,1'b0, 16'h7777, 16'h7777, 1'b0},
      '{"R5",  16'h89AB, 16'h6666, 1'b1,1'b0, 1'b0,1'b0, 1'b0,1'b0, 1'b1,1'b1, 16'h89AB, 16'h89AB, 1'b0},
      '{"R8",  16'h0000, 16'hFFFF, 1'b0,1'b0, 1'b0,1'b0, 1'b0,1'b0, 1'b1,1'b0, 16'h89AB, 16'h89AB, 1'b0},
      '{"R8",  16'h0000, 16'hFFFF, 1'b0,1'b0, 1'b0,1'b0, 1'b0,1'b0, 1'b1,1'b0, 16'h89AB, 16'h89AB, 1'b0},
      '{"R9",  16'h0000, 16'h1357, 1'b0,1'b1, 1'b0,1'b0, 1'b0,1'b0, 1'b1,1'b0, 16'h1357, 16'h1357, 1'b1},
      '{"R8",  16'h0000, 16'hFFFF, 1'b0,1'b0, 1'b0,1'b0, 1'b0,1'b0, 1'b1,1'b0, 16'h1357, 16'h1357, 1'b0},
      '{"R2",  16'h2468, 16'hFFFF, 1'b1,1'b1, 1'b1,1'b0, 1'b0,1'b0, 1'b0,1'b1, 16'h2468, 16'hFFFF, 1'b0},
      '{"R2",  16'hACE0, 16'hFFFF, 1'b1,1'b1, 1'b1,1'b0, 1'b0,1'b0, 1'b0,1'b1, 16'hACE0, 16'hFFFF, 1'b0},
      '{"R2",  16'h0000, 16'hFFFF, 1'b1,1'b0, 1'b0,1'b0, 1'b1,1'b0, 1'b1,1'b1, 16'h0000, 16'h2468, 1'b0}
   };

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic apply(input vec_t v);
      a_in       = v.ain;
      b_in       = v.bin;
      a_ext_en   = {LANES{v.aext}};
      b_ext_en   = {LANES{v.bext}};
      stb_ab     = {LANES{v.sab_stb}};
      stb_ba     = {LANES{v.sba_stb}};
      use_reg_ab = {LANES{v.rab}};
      use_reg_ba = {LANES{v.rba}};
      drive_b    = {LANES{v.drb}};
      drive_a_n  = {LANES{v.dran}};
   endtask

   task automatic stored_both();
      a_ext_en = '0; b_ext_en = '0; stb_ab = '0; stb_ba = '0;
      use_reg_ab = '1; use_reg_ba = '1; drive_b = '1; drive_a_n = '0;
   endtask

   initial begin
      #(CLK_P * 20000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0;
      a_in = 16'hDEAD; b_in = 16'hBEEF;
      stored_both();

      // R1: registers cleared while reset is held
      repeat (2) @(posedge clk);
      @(negedge clk);
      chk("R1", "a_bus in reset", a_bus, 16'h0000);
      chk("R1", "b_bus in reset", b_bus, 16'h0000);
      chk("R4", "a_oe with drive_a_n low", a_oe, 2'b11);
      chk("R4", "b_oe with drive_b high", b_oe, 2'b11);

      @(posedge clk); #1 rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "a_bus after reset", a_bus, 16'h0000);
      chk("R1", "b_bus after reset", b_bus, 16'h0000);

      // R1: hold register cleared, drive-both live with no external source
      @(posedge clk); #1 use_reg_ab = '0; use_reg_ba = '0;
      @(negedge clk);
      chk("R1", "a_bus live loop after reset", a_bus, 16'h0000);
      chk("R8", "b_bus live loop after reset", b_bus, 16'h0000);

      // Table walk: each step applied after a rising edge, read at the falling edge
      for (int i = 0; i < NV; i++) begin
         @(posedge clk); #1 apply(VT[i]);
         @(negedge clk);
         chk($sformatf("%s", VT[i].tag), $sformatf("a_bus step %0d", i), a_bus, VT[i].exp_a);
         chk($sformatf("%s", VT[i].tag), $sformatf("b_bus step %0d", i), b_bus, VT[i].exp_b);
         chk($sformatf("%s", VT[i].tag), $sformatf("conflict step %0d", i), conflict,
             {LANES{VT[i].exp_cf}});
      end
      // A-side register now 2468, B-side register 7777

      // R7: lane 0 drives B from its register, lane 1 stays isolated
      @(posedge clk); #1
      a_in = 16'h0000; b_in = 16'hABCD; a_ext_en = 2'b11; b_ext_en = 2'b10;
      stb_ab = 2'b00; stb_ba = 2'b00; use_reg_ab = 2'b01; use_reg_ba = 2'b00;
      drive_b = 2'b01; drive_a_n = 2'b11;
      @(negedge clk);
      chk("R7", "b_bus mixed lanes", b_bus, 16'hAB68);
      chk("R7", "b_oe mixed lanes", b_oe, 2'b01);
      chk("R7", "conflict mixed lanes", conflict, 2'b00);

      // R7: strobe lane 1 only, then read both lanes from their registers
      @(posedge clk); #1 a_in = 16'h9911; stb_ab = 2'b10;
      @(posedge clk); #1 stored_both();
      @(negedge clk);
      chk("R7", "b_bus after lane 1 load", b_bus, 16'h9968);
      chk("R10", "a_bus from B-side registers", a_bus, 16'h7777);

      // R1: reset in mid-run clears stored data
      @(posedge clk); #1 rst_n = 1'b0;
      @(negedge clk);
      chk("R1", "a_bus mid-run reset", a_bus, 16'h0000);
      chk("R1", "b_bus mid-run reset", b_bus, 16'h0000);
      @(posedge clk); #1 rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "b_bus after mid-run reset", b_bus, 16'h0000);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule